// File: doc/BRIEF.md
# Six-Pin Debounced GPIO Port

This block is one general-purpose I/O port of six pins behind a byte-wide register interface. A bus master writes registers with a one-cycle write strobe and reads them through a combinational read port. For each pin the registers control the pad (driven level, drive enable, pull-up request), the input path (enable), and interrupt generation (mask, edge polarity, sticky flag).

Every raw pin level passes through a two-flop synchroniser and then a chattering filter. A new level is accepted only after it has held without a break for a programmable number of clock periods. Pins 3 to 0 share one filter setting and pins 5 and 4 share another. The filtered level, gated by the input enable, is what software reads and what the edge detector watches. A detected edge of the selected polarity sets a sticky flag. The single interrupt request output is high while any flag with its mask bit set is pending.

Top module: `gpio6_port`

## Requirements
- R1: After reset the input-enable register (address 0x8) and the pull-up register (address 0x3) read 0x2f. The output-data (0x1), output-enable (0x2), mask (0x4), edge-select (0x5), flag (0x6) and filter (0x7) registers read 0, the input register (0x0) reads 0, and `pad_pu` equals 0x2f.
- R2: Only bits 5:0 of the per-pin registers are stored, and bits 7:6 read as 0. In the filter register only bits 6:4 and 2:0 are stored, and bits 7 and 3 read as 0. Addresses 0x9 to 0xf read as 0.
- R3: `pad_out`, `pad_oe` and `pad_pu` follow the output-data, output-enable and pull-up registers one cycle after the write.
- R4: With filter code 0, the input register (address 0x0) shows a pin level that changed before clock edge 1 from edge 3 on, and not before. A pin whose input-enable bit is 0 reads 0.
- R5: Filter code c from 1 to 7 sets a hold time N = 2^(7+c) clock periods (256 up to 16384). A level that changed before edge 1 and stays stable reaches the input register at edge N+2, and not before.
- R6: A new level that reverts before its hold time has elapsed never reaches the input register and raises no flag.
- R7: Filter register bits 2:0 hold the code for pins 3:0, and bits 6:4 hold the code for pins 5:4. Each group is timed only by its own code.
- R8: Edge-select bit value 0 makes a pin's flag set on a rising filtered edge, and value 1 makes it set on a falling edge. The flag (address 0x6) is set one edge after the input register changes.
- R9: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R10: When a flag's edge is detected in the same cycle as a write-1 clear of that flag, the flag ends up set.
- R11: `irq` is high exactly when some flag bit and its mask bit are both 1. All mask bits reset to 0.
- R12: A write that changes a group's filter code restarts the hold count of that group's pins. A pending level then needs the full new hold time, counted from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one clock cycle |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pin_in | input | 6 | Raw pin levels from the pads |
| pad_out | output | 6 | Level driven to each pad |
| pad_oe | output | 6 | Pad driver enable |
| pad_pu | output | 6 | Pull-up request per pad |
| irq | output | 1 | Combined masked interrupt request |

## Verification
A pin level changed before clock edge 1 reaches the input register at edge 3 with code 0, or at edge N+2 with filter code c, where N is the hold time. The matching flag follows one edge later. Register writes and pad outputs settle one edge after the strobe, and `irq` follows the flag and mask registers with no extra delay. The bench changes inputs on falling edges, counts rising edges from that point, and reads once just before the due edge and once just after it. The code-change check reads at a point where an unrestarted count would already have finished.

// File: rtl/gpio6_pkg.sv
package gpio6_pkg;

    localparam int unsigned NPINS   = 6;
    localparam int unsigned LO_W    = 4;
    localparam int unsigned HI_W    = NPINS - LO_W;
    localparam int unsigned CODE_W  = 3;
    localparam int unsigned ADDR_W  = 4;
    localparam int unsigned DATA_W  = 8;

    localparam logic [ADDR_W-1:0] A_IN   = 4'h0;
    localparam logic [ADDR_W-1:0] A_OUT  = 4'h1;
    localparam logic [ADDR_W-1:0] A_OE   = 4'h2;
    localparam logic [ADDR_W-1:0] A_PULL = 4'h3;
    localparam logic [ADDR_W-1:0] A_MASK = 4'h4;
    localparam logic [ADDR_W-1:0] A_EDGE = 4'h5;
    localparam logic [ADDR_W-1:0] A_FLAG = 4'h6;
    localparam logic [ADDR_W-1:0] A_FILT = 4'h7;
    localparam logic [ADDR_W-1:0] A_IEN  = 4'h8;

    localparam logic [NPINS-1:0] IEN_RST  = 6'h2f;
    localparam logic [NPINS-1:0] PULL_RST = 6'h2f;

    typedef struct packed {
        logic [NPINS-1:0]  dout;
        logic [NPINS-1:0]  oe;
        logic [NPINS-1:0]  pull;
        logic [NPINS-1:0]  ien;
        logic [NPINS-1:0]  mask;
        logic [NPINS-1:0]  esel;
        logic [NPINS-1:0]  flag;
        logic [NPINS-1:0]  prev;
        logic [CODE_W-1:0] code_lo;
        logic [CODE_W-1:0] code_hi;
    } port_regs_t;

endpackage

// File: rtl/gpio6_sync.sv
module gpio6_sync #(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;

endmodule

// File: rtl/gpio6_dbnc.sv
module gpio6_dbnc #(
    parameter int unsigned W         = 4,
    parameter int unsigned CODE_W    = 3,
    parameter int unsigned BASE_LOG2 = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    input  logic [W-1:0]      din,
    output logic [W-1:0]      dout
);

    // widest count: 2^(BASE_LOG2 + 2^CODE_W - 2) - 1
    localparam int unsigned CNT_W = BASE_LOG2 + (1 << CODE_W) - 2;

    typedef struct packed {
        logic [W-1:0]            filt;
        logic [W-1:0][CNT_W-1:0] cnt;
        logic [CODE_W-1:0]       code_prev;
    } dbnc_t;

    dbnc_t            st_d, st_q;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] term;
    logic             code_chg;

    always_comb begin
        span = (CNT_W+1)'(1) << (BASE_LOG2 + 32'(code) - 1);
        term = (code == '0) ? '0 : CNT_W'(span - (CNT_W+1)'(1));
    end

    assign code_chg = (code != st_q.code_prev);

    always_comb begin
        st_d           = st_q;
        st_d.code_prev = code;
        for (int i = 0; i < int'(W); i++) begin
            if (din[i] == st_q.filt[i] || code_chg) begin
                st_d.cnt[i] = '0;
            end else if (st_q.cnt[i] == term) begin
                st_d.filt[i] = din[i];
                st_d.cnt[i]  = '0;
            end else begin
                st_d.cnt[i] = st_q.cnt[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.filt;

    for (genvar g = 0; g < int'(W); g++) begin : g_chk
        // a filtered level only ever moves to the level the input held
        assert_filt_follows_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.filt[g] != $past(st_q.filt[g])) |-> (st_q.filt[g] == $past(din[g])));
        // with a settled code the count never passes the hold limit
        assert_count_bounded_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (code == st_q.code_prev) |-> (st_q.cnt[g] <= term));
    end

endmodule

// File: rtl/gpio6_port.sv
module gpio6_port
    import gpio6_pkg::*;
#(
    parameter int unsigned FILT_BASE_LOG2 = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_pu,
    output logic              irq
);

    localparam port_regs_t RST_REGS = '{
        dout: '0, oe: '0, pull: PULL_RST, ien: IEN_RST, mask: '0,
        esel: '0, flag: '0, prev: '0, code_lo: '0, code_hi: '0
    };

    port_regs_t       st_d, st_q;
    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] filt;
    logic [NPINS-1:0] gated;
    logic [NPINS-1:0] set_vec;
    logic [NPINS-1:0] clr_vec;
    logic             unused_wbits;

    assign unused_wbits = ^{bus_wdata[7], bus_wdata[3]};

    gpio6_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    gpio6_dbnc #(.W(LO_W), .CODE_W(CODE_W), .BASE_LOG2(FILT_BASE_LOG2)) u_dbnc_lo (
        .clk   (clk),
        .rst_n (rst_n),
        .code  (st_q.code_lo),
        .din   (pin_sync[LO_W-1:0]),
        .dout  (filt[LO_W-1:0])
    );

    gpio6_dbnc #(.W(HI_W), .CODE_W(CODE_W), .BASE_LOG2(FILT_BASE_LOG2)) u_dbnc_hi (
        .clk   (clk),
        .rst_n (rst_n),
        .code  (st_q.code_hi),
        .din   (pin_sync[NPINS-1:LO_W]),
        .dout  (filt[NPINS-1:LO_W])
    );

    always_comb begin
        gated   = filt & st_q.ien;
        set_vec = (gated & ~st_q.prev & ~st_q.esel)
                | (~gated & st_q.prev & st_q.esel);
        clr_vec = (bus_wr && bus_addr == A_FLAG) ? bus_wdata[NPINS-1:0] : '0;
    end

    always_comb begin
        st_d      = st_q;
        st_d.prev = gated;
        st_d.flag = (st_q.flag & ~clr_vec) | set_vec;
        if (bus_wr) begin
            unique case (bus_addr)
                A_OUT:   st_d.dout = bus_wdata[NPINS-1:0];
                A_OE:    st_d.oe   = bus_wdata[NPINS-1:0];
                A_PULL:  st_d.pull = bus_wdata[NPINS-1:0];
                A_MASK:  st_d.mask = bus_wdata[NPINS-1:0];
                A_EDGE:  st_d.esel = bus_wdata[NPINS-1:0];
                A_IEN:   st_d.ien  = bus_wdata[NPINS-1:0];
                A_FILT: begin
                    st_d.code_lo = bus_wdata[2:0];
                    st_d.code_hi = bus_wdata[6:4];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_REGS;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_IN:    bus_rdata[NPINS-1:0] = gated;
            A_OUT:   bus_rdata[NPINS-1:0] = st_q.dout;
            A_OE:    bus_rdata[NPINS-1:0] = st_q.oe;
            A_PULL:  bus_rdata[NPINS-1:0] = st_q.pull;
            A_MASK:  bus_rdata[NPINS-1:0] = st_q.mask;
            A_EDGE:  bus_rdata[NPINS-1:0] = st_q.esel;
            A_FLAG:  bus_rdata[NPINS-1:0] = st_q.flag;
            A_IEN:   bus_rdata[NPINS-1:0] = st_q.ien;
            A_FILT:  bus_rdata = {1'b0, st_q.code_hi, 1'b0, st_q.code_lo};
            default: bus_rdata = '0;
        endcase
    end

    assign pad_out = st_q.dout;
    assign pad_oe  = st_q.oe;
    assign pad_pu  = st_q.pull;
    assign irq     = |(st_q.flag & st_q.mask);

    // flags drop only where a write-1 clear was applied
    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.flag) & ~$past(clr_vec) & ~st_q.flag) == '0);

    // a detected edge always leaves its flag set, even under a clear
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(set_vec) & ~st_q.flag) == '0);

    // the request only rises after a register write or a new edge
    assert_irq_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(bus_wr) || ($past(set_vec) != '0)));

    // the output-data pad follows a write one cycle later
    assert_pad_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_wr) && $past(bus_addr) == A_OUT) |-> (pad_out == $past(bus_wdata[NPINS-1:0])));

    // the top read bit is never stored anywhere
    always_comb begin
        if (rst_n) begin
            assert_rsvd_top_bit_R2: assert (bus_rdata[7] == 1'b0);
        end
    end

endmodule

// File: tb/gpio6_port_tb.sv
`timescale 1ns/1ps
module gpio6_port_tb_top;

    localparam int K_RD = 0, K_IRQ = 1, K_POUT = 2, K_POE = 3, K_PPU = 4;

    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [5:0] pin_in = 6'h00;
    logic [5:0] pad_out, pad_oe, pad_pu;
    logic       irq;

    item_t q[$];
    event  sample_ev;
    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    gpio6_port dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .pad_pu    (pad_pu),
        .irq       (irq)
    );

    // monitor: pops expected items and compares them to the live outputs
    initial begin
        forever begin
            @(sample_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = q.pop_front();
                case (it.kind)
                    K_IRQ:   act = {7'b0, irq};
                    K_POUT:  act = {2'b0, pad_out};
                    K_POE:   act = {2'b0, pad_oe};
                    K_PPU:   act = {2'b0, pad_pu};
                    default: act = bus_rdata;
                endcase
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s act=0x%02h exp=0x%02h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic expect_val(input int kind, input logic [3:0] a, input logic [7:0] e, input string tag);
        bus_addr = a;
        #0.1;
        q.push_back('{kind: kind, exp: e, tag: tag});
        -> sample_ev;
        #0.1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog (all requirements) act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        edges(3);
        rst_n = 1'b1;
        edges(1);

        // R1 reset state
        expect_val(K_RD, 4'h8, 8'h2f, "R1 ien reset");
        expect_val(K_RD, 4'h3, 8'h2f, "R1 pull reset");
        expect_val(K_RD, 4'h1, 8'h00, "R1 out reset");
        expect_val(K_RD, 4'h4, 8'h00, "R1 mask reset");
        expect_val(K_PPU, 4'h0, 8'h2f, "R1 pad_pu reset");
        edges(1);
        expect_val(K_RD, 4'h2, 8'h00, "R1 oe reset");
        expect_val(K_RD, 4'h5, 8'h00, "R1 edge reset");
        expect_val(K_RD, 4'h6, 8'h00, "R1 flag reset");
        expect_val(K_RD, 4'h7, 8'h00, "R1 filt reset");
        expect_val(K_RD, 4'h0, 8'h00, "R1 in reset");

        // R2 reserved bits and unmapped addresses
        wr(4'h1, 8'hff);
        expect_val(K_RD, 4'h1, 8'h3f, "R2 out bits 7:6");
        expect_val(K_POUT, 4'h0, 8'h3f, "R3 pad_out");
        wr(4'h7, 8'hff);
        expect_val(K_RD, 4'h7, 8'h77, "R2 filt bits 7,3");
        expect_val(K_RD, 4'hc, 8'h00, "R2 unmapped");
        wr(4'h7, 8'h00);

        // R3 pad outputs
        wr(4'h2, 8'h15);
        expect_val(K_POE, 4'h0, 8'h15, "R3 pad_oe");
        wr(4'h3, 8'h0a);
        expect_val(K_PPU, 4'h0, 8'h0a, "R3 pad_pu");

        // R4 unfiltered latency and input gating
        wr(4'h8, 8'h3f);
        pin_in = 6'h01;
        edges(2);
        expect_val(K_RD, 4'h0, 8'h00, "R4 before edge 3");
        edges(1);
        expect_val(K_RD, 4'h0, 8'h01, "R4 at edge 3");
        wr(4'h8, 8'h1f);
        pin_in = 6'h21;
        edges(5);
        expect_val(K_RD, 4'h0, 8'h01, "R4 disabled pin reads 0");
        wr(4'h8, 8'h3f);
        pin_in = 6'h00;
        edges(5);
        wr(4'h6, 8'h3f);
        expect_val(K_RD, 4'h6, 8'h00, "R9 clear all");

        // R8 edge polarity
        wr(4'h5, 8'h02);
        pin_in = 6'h06;
        edges(3);
        expect_val(K_RD, 4'h6, 8'h00, "R8 flag not before edge 4");
        edges(1);
        expect_val(K_RD, 4'h6, 8'h04, "R8 rising sets pin2 only");
        pin_in = 6'h00;
        edges(4);
        expect_val(K_RD, 4'h6, 8'h06, "R8 falling sets pin1");

        // R9 write-1 clear, write-0 keep
        wr(4'h6, 8'h02);
        expect_val(K_RD, 4'h6, 8'h04, "R9 clear pin1");
        wr(4'h6, 8'h00);
        expect_val(K_RD, 4'h6, 8'h04, "R9 write 0 keeps");
        wr(4'h6, 8'h04);
        expect_val(K_RD, 4'h6, 8'h00, "R9 clear pin2");

        // R11 masked request
        wr(4'h5, 8'h00);
        pin_in = 6'h08;
        edges(4);
        expect_val(K_IRQ, 4'h0, 8'h00, "R11 masked off");
        wr(4'h4, 8'h08);
        expect_val(K_IRQ, 4'h0, 8'h01, "R11 mask on");
        wr(4'h4, 8'h00);
        expect_val(K_IRQ, 4'h0, 8'h00, "R11 mask off again");

        // R10 set beats clear (flag3 still set from above)
        pin_in = 6'h00;
        edges(5);
        pin_in = 6'h08;
        edges(3);
        wr(4'h6, 8'h08);
        expect_val(K_RD, 4'h6, 8'h08, "R10 set wins");
        wr(4'h6, 8'h08);
        expect_val(K_RD, 4'h6, 8'h00, "R10 later clear");
        pin_in = 6'h00;
        edges(5);
        wr(4'h6, 8'h3f);

        // R5 filtered hold times
        wr(4'h7, 8'h01);
        pin_in = 6'h01;
        edges(257);
        expect_val(K_RD, 4'h0, 8'h00, "R5 code1 before 258");
        edges(1);
        expect_val(K_RD, 4'h0, 8'h01, "R5 code1 at 258");
        wr(4'h7, 8'h02);
        pin_in = 6'h00;
        edges(513);
        expect_val(K_RD, 4'h0, 8'h01, "R5 code2 before 514");
        edges(1);
        expect_val(K_RD, 4'h0, 8'h00, "R5 code2 at 514");
        wr(4'h6, 8'h3f);

        // R6 glitch rejection
        wr(4'h7, 8'h01);
        pin_in = 6'h01;
        edges(200);
        pin_in = 6'h00;
        edges(400);
        expect_val(K_RD, 4'h0, 8'h00, "R6 short pulse dropped");
        expect_val(K_RD, 4'h6, 8'h00, "R6 no flag");

        // R7 independent groups
        wr(4'h7, 8'h10);
        pin_in = 6'h11;
        edges(3);
        expect_val(K_RD, 4'h0, 8'h01, "R7 low group unfiltered");
        edges(254);
        expect_val(K_RD, 4'h0, 8'h01, "R7 high group before 258");
        edges(1);
        expect_val(K_RD, 4'h0, 8'h11, "R7 high group at 258");

        // R12 code change restarts the count
        pin_in = 6'h01;
        edges(200);
        wr(4'h7, 8'h20);
        edges(399);
        expect_val(K_RD, 4'h0, 8'h11, "R12 restarted count pending");
        edges(113);
        expect_val(K_RD, 4'h0, 8'h11, "R12 before full new hold");
        edges(1);
        expect_val(K_RD, 4'h0, 8'h01, "R12 after full new hold");

        edges(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule